// File: doc/BRIEF.md
# Sequenced Pattern Trigger

This unit holds a short program of match stages and walks through it one stage at a time against a narrow probe bus. It runs on the streamer clock. Stage entries arrive as trigger elements from the shared element stream: an upstream decoder presents each entry on a load strobe, together with a flag that marks the last stage of the program. Once the last stage has been stored, the unit starts comparing the probe against stage 0. Each probe match moves it on to the next stage. A match on the last stage raises the trigger output, and the output side uses that signal as its permission to start reading.

The trigger output stays high until a rearm request arrives. The request is built outside the unit from a pending retrigger and the trigger itself. A rearm sends the unit back to waiting on stage 0 and keeps the stored program, so a new trigger condition can be awaited without a global reset. A force input raises the trigger straight away from any state.

The controller has four states. Idle holds no program. Load is collecting stage entries. Wait is matching stages. Triggered holds the trigger output high.

Top module: `trig_chain`

## Requirements
- R1: After reset, `trig_out` is 0 and the unit is in Idle with an empty program.
- R2: In Idle or Load, each cycle with `ld_valid` high stores `ld_pat` as the next stage. A cycle whose `ld_last` is also high ends loading, and matching then begins at stage 0.
- R3: Stages are matched strictly in load order. A stage is satisfied when `probe` equals its pattern at a rising edge. `trig_out` is high in the cycle after the edge at which the last stage was satisfied.
- R4: A probe value that differs from the current stage's pattern keeps the unit on that same stage. It never falls back to an earlier stage, even if the value equals an earlier stage's pattern.
- R5: At most `STAGES` (default 4) stages are stored. A load beyond that is ignored, but its `ld_last` flag still ends loading.
- R6: `force_trig` high at a rising edge makes `trig_out` high in the next cycle, from any state. Any load or rearm in that same cycle is ignored.
- R7: While triggered, `trig_out` stays high until `rearm` is high at an edge without `force_trig`. The unit then returns to matching from stage 0 with the program retained. `rearm` has no effect outside the triggered state.
- R8: `ld_valid` has no effect while the unit is matching or triggered.
- R9: A rearm taken while the program is empty, which can only happen after a force from Idle, returns the unit to Idle, where it accepts a new program.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Streamer clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ld_valid | input | 1 | Stage entry present this cycle |
| ld_pat | input | PAT_W | Pattern of the stage entry |
| ld_last | input | 1 | Entry is the last stage of the program |
| probe | input | PAT_W | Sampled bus compared against the current stage |
| force_trig | input | 1 | Raise the trigger unconditionally |
| rearm | input | 1 | Leave the triggered state and wait for the program again |
| trig_out | output | 1 | Trigger; high while triggered |

## Verification
The bench presents probe values that match an earlier stage while a later one is pending. A design that restarted or fell back on a mismatch would then trigger late or never. It loads a fifth stage carrying the last-stage flag: a design that stored it would wait for a pattern that must not matter, and one that dropped the flag along with the data would stay in loading. It rearms with an empty program after a force from Idle, which would trigger at once or hang if mishandled. It also puts force, rearm and loads in the same cycle to check the priority order. A long random run is then checked every cycle against a behavioural model, which catches off-by-one stage advances and a trigger output one cycle early or late.

// File: rtl/trig_chain.sv
module trig_chain #(
  parameter int PAT_W  = 3,
  parameter int STAGES = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ld_valid,
  input  logic [PAT_W-1:0] ld_pat,
  input  logic             ld_last,
  input  logic [PAT_W-1:0] probe,
  input  logic             force_trig,
  input  logic             rearm,
  output logic             trig_out
);
  localparam int IW = (STAGES > 1) ? $clog2(STAGES) : 1;
  localparam int CW = $clog2(STAGES + 1);

  typedef enum logic [1:0] {S_IDLE, S_LOAD, S_WAIT, S_TRIG} st_t;

  st_t             st;
  logic [PAT_W-1:0] pat [STAGES];
  logic [CW-1:0]   cnt;
  logic [IW-1:0]   cur;

  wire hit       = (probe == pat[cur]);
  wire last_stg  = ((CW'(cur) + CW'(1)) == cnt);
  wire has_room  = (cnt < CW'(STAGES));

  assign trig_out = (st == S_TRIG);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st  <= S_IDLE;
      cnt <= '0;
      cur <= '0;
      for (int i = 0; i < STAGES; i++) pat[i] <= '0;
    end else if (force_trig) begin
      st <= S_TRIG;
    end else begin
      case (st)
        S_IDLE: if (ld_valid) begin
          pat[0] <= ld_pat;
          cnt    <= CW'(1);
          cur    <= '0;
          st     <= ld_last ? S_WAIT : S_LOAD;
        end
        S_LOAD: if (ld_valid) begin
          if (has_room) begin
            pat[IW'(cnt)] <= ld_pat;
            cnt           <= cnt + CW'(1);
          end
          if (ld_last) begin
            cur <= '0;
            st  <= S_WAIT;
          end
        end
        S_WAIT: if (hit) begin
          if (last_stg) st <= S_TRIG;
          else          cur <= cur + IW'(1);
        end
        default: if (rearm) begin
          cur <= '0;
          st  <= (cnt == '0) ? S_IDLE : S_WAIT;
        end
      endcase
    end
  end

  AST_STAGE_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CW'(STAGES)); // R5
  AST_RISE_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(trig_out) |-> $past(force_trig || st == S_WAIT)); // R3
  AST_FORCE_TRIG: assert property (@(posedge clk) disable iff (!rst_n)
    force_trig |=> trig_out); // R6
  AST_TRIG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (trig_out && !rearm) |=> trig_out); // R7
  AST_REARM_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
    (trig_out && rearm && !force_trig && cnt != '0) |=> (st == S_WAIT && cur == '0)); // R7
  AST_MISS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_WAIT && !hit && !force_trig) |=> (st == S_WAIT && $stable(cur))); // R4
  AST_PROG_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_WAIT || st == S_TRIG) |=> $stable(cnt)); // R8
endmodule

// File: tb/tb_trig_chain.sv
module tb_trig_chain;
  localparam int CLK_PERIOD = 10;
  localparam int PW = 3;
  localparam int NS = 4;

  logic clk = 0, rst_n = 0;
  logic ld_valid = 0, ld_last = 0, force_trig = 0, rearm = 0;
  logic [PW-1:0] ld_pat = '0, probe = '0;
  logic trig_out;

  trig_chain #(.PAT_W(PW), .STAGES(NS)) dut (
    .clk(clk), .rst_n(rst_n), .ld_valid(ld_valid), .ld_pat(ld_pat),
    .ld_last(ld_last), .probe(probe), .force_trig(force_trig),
    .rearm(rearm), .trig_out(trig_out));

  always #(CLK_PERIOD/2) clk = ~clk;

  int compared = 0, mismatched = 0;
  string tag = "R1";
  bit finished = 0;

  // behavioural reference: 0 idle, 1 load, 2 wait, 3 triggered
  int mst = 0, mcur = 0;
  int mprog[$];

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mst = 0; mcur = 0; mprog.delete();
    end else if (force_trig) begin
      mst = 3;
    end else if (mst == 0) begin
      if (ld_valid) begin
        mprog.delete(); mprog.push_back(int'(ld_pat)); mcur = 0;
        mst = ld_last ? 2 : 1;
      end
    end else if (mst == 1) begin
      if (ld_valid) begin
        if (mprog.size() < NS) mprog.push_back(int'(ld_pat));
        if (ld_last) begin mst = 2; mcur = 0; end
      end
    end else if (mst == 2) begin
      if (int'(probe) == mprog[mcur]) begin
        if (mcur == mprog.size() - 1) mst = 3;
        else mcur++;
      end
    end else begin
      if (rearm) begin
        mcur = 0;
        mst = (mprog.size() == 0) ? 0 : 2;
      end
    end
  end

  always @(negedge clk) if (!finished) begin
    compared++;
    if (trig_out !== (mst == 3)) begin
      mismatched++;
      $display("FAIL %s t=%0t trig_out actual=%b expected=%b", tag, $time, trig_out, (mst == 3));
    end
  end

  task automatic step(input logic lv, input logic [PW-1:0] lp, input logic ll,
                      input logic [PW-1:0] pr, input logic f, input logic ra);
    @(negedge clk); #1;
    ld_valid = lv; ld_pat = lp; ld_last = ll; probe = pr; force_trig = f; rearm = ra;
  endtask

  task automatic prb(input logic [PW-1:0] pr);
    step(0, 0, 0, pr, 0, 0);
  endtask

  task automatic do_reset();
    @(negedge clk); #1; rst_n = 0;
    ld_valid = 0; ld_last = 0; force_trig = 0; rearm = 0;
    @(negedge clk); @(negedge clk); #1; rst_n = 1;
  endtask

  initial begin
    tag = "R1";
    repeat (3) @(negedge clk);
    #1 rst_n = 1;
    prb(3'b001); prb(3'b001);
    tag = "R2";
    step(1, 3'b001, 0, 0, 0, 0);
    step(1, 3'b010, 0, 3'b001, 0, 0);
    step(1, 3'b100, 1, 3'b001, 0, 0);
    tag = "R4";
    prb(3'b000); prb(3'b010); prb(3'b100);
    tag = "R3";
    prb(3'b001); prb(3'b111);
    tag = "R4";
    prb(3'b001);
    tag = "R3";
    prb(3'b010); prb(3'b100); prb(3'b000); prb(3'b000);
    tag = "R8";
    step(1, 3'b111, 1, 0, 0, 0); prb(0);
    tag = "R7";
    step(0, 0, 0, 3'b001, 0, 1);
    prb(3'b001); prb(3'b010);
    step(0, 0, 0, 3'b000, 0, 1);
    prb(3'b100); prb(0); prb(0);
    tag = "R8";
    step(1, 3'b011, 1, 3'b011, 0, 0); prb(3'b011);
    tag = "R6";
    step(0, 0, 0, 0, 1, 1); prb(0);
    step(0, 0, 0, 0, 0, 1);
    prb(3'b001); step(0, 0, 0, 0, 1, 0); prb(0);

    tag = "R9";
    do_reset();
    step(1, 3'b101, 0, 0, 1, 0); prb(0);
    step(0, 0, 0, 0, 0, 1); prb(3'b101);
    step(1, 3'b110, 1, 0, 0, 0);
    prb(3'b110); prb(0);

    tag = "R5";
    do_reset();
    step(1, 3'b001, 0, 0, 0, 0);
    step(1, 3'b010, 0, 0, 0, 0);
    step(1, 3'b011, 0, 0, 0, 0);
    step(1, 3'b100, 0, 0, 0, 0);
    step(1, 3'b101, 1, 0, 0, 0);
    prb(3'b001); prb(3'b010); prb(3'b011); prb(3'b100); prb(0); prb(0);

    tag = "R6";
    do_reset();
    step(1, 3'b111, 0, 0, 0, 0);
    step(1, 3'b110, 0, 0, 1, 0);
    prb(0); step(0, 0, 0, 0, 0, 1); prb(3'b111); prb(3'b110); prb(0);

    tag = "R3";
    do_reset();
    for (int n = 0; n < 4000; n++) begin
      logic [PW-1:0] pr;
      pr = PW'($urandom_range(0, 7));
      if (($urandom % 200) == 0) do_reset();
      else step(($urandom % 4) == 0, PW'($urandom_range(0, 7)), ($urandom % 3) == 0,
                pr, ($urandom % 60) == 0, ($urandom % 6) == 0);
    end
    prb(0); prb(0);
    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    if (!finished) begin
      finished = 1;
      compared++; mismatched++;
      $display("FAIL watchdog expired in %s", tag);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end
endmodule